// File: doc/BRIEF.md
# SPI Slave Data Path with Buffer Error Detection

This block is the data path of a single SPI slave channel. An external master drives the serial clock, chip select and serial data in clock mode 0 with 8-bit words, most significant bit first. On the host side, one holding register carries the next outgoing word and another carries the last word that came in. The block watches both registers and reports two data-loss errors. A transmit underflow means the master started a word before the host had refilled the outgoing register. A receive overflow means a word arrived while the previous one was still unread.

Each event, plus a "receive register filled" event, sets its own sticky status bit. Software clears a status bit by writing one to it. Each status bit has an enable bit, and one interrupt line is raised while any enabled status bit is set. A mode input selects transmit-and-receive or receive-only operation. The serial pins are synchronised into the system clock, which must run at least four times faster than the serial clock.

A small state machine follows each word. Its states are `ST_OFF` (channel disabled), `ST_IDLE` (enabled, chip select high), `ST_ARMED` (selected, waiting for the first clock edge of a word) and `ST_SHIFT` (bits being exchanged). Its transitions are:
- enable: `ST_OFF`→`ST_IDLE`.
- select: `ST_IDLE`→`ST_ARMED` on chip select low.
- start: `ST_ARMED`→`ST_SHIFT` on the first rising edge.
- word end: `ST_SHIFT`→`ST_ARMED` on the eighth rising edge.
- deselect: `ST_ARMED`/`ST_SHIFT`→`ST_IDLE` on chip select high.
- disable: any state→`ST_OFF`.

Top module: `spi_slv_errdet`

## Requirements
- R1: After reset, `status` is 000, `irq` is 0 and `miso` is 0.
- R2: In transmit-and-receive mode (`rx_only`=0), a word shifts out on `miso` MSB first, sampled by the master on rising `sclk`. The word is the last byte written through `tx_wr`, loaded at the first rising edge after `cs_n` falls. The byte received on `mosi` appears on `rx_rdata`.
- R3: Status bit 2 (receive filled) is set when a word completes while the receive register is empty. A `rx_rd` pulse empties the register, so the next word sets bit 2 again and does not count as overflow.
- R4: Status bit 0 (underflow) is set when all of the following hold at the start of a word: the channel is enabled, the mode is transmit-and-receive, the host has written since enable, and no fresh byte has been written since the previous word start. The stale byte is sent again on `miso`.
- R5: Underflow is never flagged while no `tx_wr` has occurred since the channel was last enabled.
- R6: Status bit 1 (overflow) is set when a word completes while the previous received word is unread. `rx_rdata` is always replaced by the new word.
- R7: With `rx_only`=1, underflow is never flagged, while receive filled and overflow work as in R3 and R6.
- R8: When `clr_wr` is high, each status bit whose `clr_mask` bit is 1 clears. Bits with mask 0 keep their value, and a status bit never clears without `clr_wr`.
- R9: `irq` is high exactly while some bit of `status & irq_en` is set. It stays high until that status bit is cleared or its enable is dropped.
- R10: Dropping `chan_en` empties both holding registers' full/empty state and forgets earlier host writes. After re-enabling, neither an underflow nor an overflow follows from state held before the disable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial clock from the master |
| cs_n | input | 1 | Active-low chip select |
| mosi | input | 1 | Serial data from the master |
| miso | output | 1 | Serial data to the master |
| chan_en | input | 1 | Channel enable |
| rx_only | input | 1 | 0 = transmit-and-receive, 1 = receive-only |
| tx_wr | input | 1 | Host write strobe for the transmit holding register |
| tx_wdata | input | 8 | Host write data |
| rx_rd | input | 1 | Host read strobe, empties the receive holding register |
| rx_rdata | output | 8 | Receive holding register |
| clr_wr | input | 1 | Status clear strobe |
| clr_mask | input | 3 | Write-one-to-clear mask (bit0 underflow, bit1 overflow, bit2 filled) |
| irq_en | input | 3 | Per-status interrupt enables, same bit order |
| status | output | 3 | Sticky status bits |
| irq | output | 1 | Interrupt request |

## Verification
The checker watches several properties on every cycle:
- Status bits never fall without a clear strobe.
- The interrupt line follows its enables.
- An underflow event only occurs with a prior host write, in transmit-and-receive mode.
- An overflow leaves the receive register marked full.
- A disabled channel drops all full/empty state and parks the state machine in `ST_OFF`.

The serial data values need the bench's scenarios. These cover the MISO byte order, the stale retransmission, the receive word replacement and the suppression of underflow after a re-enable. They run against the scoreboard's expected bytes and status words.

// File: rtl/spi_slv_pkg.sv
package spi_slv_pkg;

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_IDLE  = 2'd1,
        ST_ARMED = 2'd2,
        ST_SHIFT = 2'd3
    } slv_state_e;

    localparam int EV_UNF = 0;
    localparam int EV_OVF = 1;
    localparam int EV_RXF = 2;
    localparam int EV_NUM = 3;

endpackage

// File: rtl/spi_slv_sync.sv
module spi_slv_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_in,
    output logic level,
    output logic rise,
    output logic fall
);
    logic [STAGES-1:0] chain;
    logic              prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= {STAGES{RST_VAL}};
            prev  <= RST_VAL;
        end else begin
            chain <= {chain[STAGES-2:0], pin_in};
            prev  <= chain[STAGES-1];
        end
    end

    assign level = chain[STAGES-1];
    assign rise  = level & ~prev;
    assign fall  = ~level & prev;
endmodule

// File: rtl/spi_slv_fsm.sv
module spi_slv_fsm
    import spi_slv_pkg::*;
#(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chan_en,
    input  logic              cs_lvl,
    input  logic              sclk_rise,
    input  logic              sclk_fall,
    input  logic              mosi_lvl,
    input  logic [WORD_W-1:0] tx_hold,
    output logic              miso,
    output logic              word_start,
    output logic              word_done,
    output logic [WORD_W-1:0] rx_word,
    output slv_state_e        state
);
    localparam int CNT_W = $clog2(WORD_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_W - 1);

    slv_state_e        state_nx;
    logic [CNT_W-1:0]  bit_cnt;
    logic [WORD_W-1:0] tx_sh;
    logic [WORD_W-1:0] rx_sh;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_OFF;
        else        state <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state;
        if (!chan_en) begin
            state_nx = ST_OFF;
        end else begin
            unique case (state)
                ST_OFF:   state_nx = ST_IDLE;
                ST_IDLE:  if (!cs_lvl) state_nx = ST_ARMED;
                ST_ARMED: begin
                    if (cs_lvl)         state_nx = ST_IDLE;
                    else if (sclk_rise) state_nx = ST_SHIFT;
                end
                ST_SHIFT: begin
                    if (cs_lvl)                                state_nx = ST_IDLE;
                    else if (sclk_rise && bit_cnt == LAST_BIT) state_nx = ST_ARMED;
                end
            endcase
        end
    end

    // word boundary strobes
    always_comb begin
        word_start = 1'b0;
        word_done  = 1'b0;
        unique case (state)
            ST_ARMED: word_start = chan_en && !cs_lvl && sclk_rise;
            ST_SHIFT: word_done  = chan_en && !cs_lvl && sclk_rise && (bit_cnt == LAST_BIT);
            default: ;
        endcase
    end

    assign rx_word = {rx_sh[WORD_W-2:0], mosi_lvl};

    // shift datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            tx_sh   <= '0;
            rx_sh   <= '0;
        end else if (word_start) begin
            tx_sh   <= tx_hold;
            rx_sh   <= {rx_sh[WORD_W-2:0], mosi_lvl};
            bit_cnt <= CNT_W'(1);
        end else if (state == ST_SHIFT && !cs_lvl) begin
            if (sclk_rise) begin
                rx_sh   <= {rx_sh[WORD_W-2:0], mosi_lvl};
                bit_cnt <= (bit_cnt == LAST_BIT) ? '0 : bit_cnt + CNT_W'(1);
            end else if (sclk_fall) begin
                tx_sh   <= {tx_sh[WORD_W-2:0], 1'b0};
            end
        end
    end

    // serial output
    always_comb begin
        unique case (state)
            ST_ARMED: miso = tx_hold[WORD_W-1];
            ST_SHIFT: miso = tx_sh[WORD_W-1];
            default:  miso = 1'b0;
        endcase
    end
endmodule

// File: rtl/spi_slv_hold.sv
module spi_slv_hold #(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chan_en,
    input  logic              rx_only,
    input  logic              tx_wr,
    input  logic [WORD_W-1:0] tx_wdata,
    input  logic              rx_rd,
    input  logic              word_start,
    input  logic              word_done,
    input  logic [WORD_W-1:0] rx_word,
    output logic [WORD_W-1:0] tx_hold,
    output logic [WORD_W-1:0] rx_hold,
    output logic              tx_full,
    output logic              rx_full,
    output logic              wr_seen,
    output logic              ev_unf,
    output logic              ev_ovf,
    output logic              ev_rxf
);
    logic rx_unread;

    assign rx_unread = rx_full && !rx_rd;
    assign ev_unf    = word_start && !rx_only && wr_seen && !tx_full;
    assign ev_ovf    = word_done && rx_unread;
    assign ev_rxf    = word_done && !rx_unread;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_hold <= '0;
            tx_full <= 1'b0;
            wr_seen <= 1'b0;
        end else if (!chan_en) begin
            tx_full <= 1'b0;
            wr_seen <= 1'b0;
        end else if (tx_wr) begin
            tx_hold <= tx_wdata;
            tx_full <= 1'b1;
            wr_seen <= 1'b1;
        end else if (word_start && !rx_only) begin
            tx_full <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_hold <= '0;
            rx_full <= 1'b0;
        end else if (!chan_en) begin
            rx_full <= 1'b0;
        end else if (word_done) begin
            rx_hold <= rx_word;
            rx_full <= 1'b1;
        end else if (rx_rd) begin
            rx_full <= 1'b0;
        end
    end
endmodule

// File: rtl/spi_slv_irq.sv
module spi_slv_irq #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] events,
    input  logic         clr_wr,
    input  logic [N-1:0] clr_mask,
    input  logic [N-1:0] irq_en,
    output logic [N-1:0] status,
    output logic         irq
);
    logic [N-1:0] keep;

    assign keep = clr_wr ? ~clr_mask : {N{1'b1}};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) status <= '0;
        else        status <= (status & keep) | events;
    end

    assign irq = |(status & irq_en);
endmodule

// File: rtl/spi_slv_errdet.sv
module spi_slv_errdet
    import spi_slv_pkg::*;
#(
    parameter int WORD_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk,
    input  logic              cs_n,
    input  logic              mosi,
    output logic              miso,
    input  logic              chan_en,
    input  logic              rx_only,
    input  logic              tx_wr,
    input  logic [WORD_W-1:0] tx_wdata,
    input  logic              rx_rd,
    output logic [WORD_W-1:0] rx_rdata,
    input  logic              clr_wr,
    input  logic [EV_NUM-1:0] clr_mask,
    input  logic [EV_NUM-1:0] irq_en,
    output logic [EV_NUM-1:0] status,
    output logic              irq
);
    logic              sclk_lvl, sclk_rise, sclk_fall;
    logic              cs_lvl, cs_rise_unused, cs_fall_unused;
    logic              mosi_lvl, mosi_rise_unused, mosi_fall_unused;
    logic              word_start, word_done;
    logic [WORD_W-1:0] rx_word, tx_hold;
    logic              tx_full, rx_full, wr_seen;
    logic              ev_unf, ev_ovf, ev_rxf;
    logic [EV_NUM-1:0] events;
    slv_state_e        state;

    spi_slv_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sclk (
        .clk(clk), .rst_n(rst_n), .pin_in(sclk),
        .level(sclk_lvl), .rise(sclk_rise), .fall(sclk_fall));

    spi_slv_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_cs (
        .clk(clk), .rst_n(rst_n), .pin_in(cs_n),
        .level(cs_lvl), .rise(cs_rise_unused), .fall(cs_fall_unused));

    spi_slv_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_mosi (
        .clk(clk), .rst_n(rst_n), .pin_in(mosi),
        .level(mosi_lvl), .rise(mosi_rise_unused), .fall(mosi_fall_unused));

    spi_slv_fsm #(.WORD_W(WORD_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .chan_en(chan_en),
        .cs_lvl(cs_lvl), .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
        .mosi_lvl(mosi_lvl), .tx_hold(tx_hold), .miso(miso),
        .word_start(word_start), .word_done(word_done),
        .rx_word(rx_word), .state(state));

    spi_slv_hold #(.WORD_W(WORD_W)) u_hold (
        .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .rx_only(rx_only),
        .tx_wr(tx_wr), .tx_wdata(tx_wdata), .rx_rd(rx_rd),
        .word_start(word_start), .word_done(word_done), .rx_word(rx_word),
        .tx_hold(tx_hold), .rx_hold(rx_rdata),
        .tx_full(tx_full), .rx_full(rx_full), .wr_seen(wr_seen),
        .ev_unf(ev_unf), .ev_ovf(ev_ovf), .ev_rxf(ev_rxf));

    always_comb begin
        events         = '0;
        events[EV_UNF] = ev_unf;
        events[EV_OVF] = ev_ovf;
        events[EV_RXF] = ev_rxf;
    end

    spi_slv_irq #(.N(EV_NUM)) u_irq (
        .clk(clk), .rst_n(rst_n), .events(events),
        .clr_wr(clr_wr), .clr_mask(clr_mask), .irq_en(irq_en),
        .status(status), .irq(irq));
endmodule

// File: rtl/spi_slv_errdet_chk.sv
module spi_slv_errdet_chk
    import spi_slv_pkg::*;
#(
    parameter int N = 3
) (
    input logic         clk,
    input logic         rst_n,
    input logic         chan_en,
    input logic         rx_only,
    input logic         clr_wr,
    input logic [N-1:0] irq_en,
    input logic [N-1:0] status,
    input logic         irq,
    input logic         ev_unf,
    input logic         ev_ovf,
    input logic         wr_seen,
    input logic         tx_full,
    input logic         rx_full,
    input slv_state_e   state
);
    AST_STICKY_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_wr |=> ((status & $past(status)) == $past(status))); // R8

    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_en == '0) |-> !irq); // R9

    AST_IRQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !clr_wr) |=> (irq || (irq_en != $past(irq_en)))); // R9

    AST_UNF_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        ev_unf |-> (wr_seen && !rx_only && chan_en)); // R5

    AST_OVF_KEEPS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        ev_ovf |=> rx_full); // R6

    AST_OFF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !chan_en |=> (!tx_full && !rx_full && !wr_seen && state == ST_OFF)); // R10
endmodule

bind spi_slv_errdet spi_slv_errdet_chk #(.N(spi_slv_pkg::EV_NUM)) u_chk (
    .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .rx_only(rx_only),
    .clr_wr(clr_wr), .irq_en(irq_en), .status(status), .irq(irq),
    .ev_unf(ev_unf), .ev_ovf(ev_ovf), .wr_seen(wr_seen),
    .tx_full(tx_full), .rx_full(rx_full), .state(state));

// File: tb/spi_slv_errdet_tb.sv
module spi_slv_errdet_tb_top;
    localparam int CLK_P = 10;
    localparam int HALF  = 6;   // system clocks per SCLK half period

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
    logic       miso;
    logic       chan_en = 1'b0, rx_only = 1'b0;
    logic       tx_wr = 1'b0, rx_rd = 1'b0, clr_wr = 1'b0;
    logic [7:0] tx_wdata = '0;
    logic [7:0] rx_rdata;
    logic [2:0] clr_mask = '0, irq_en = '0;
    logic [2:0] status;
    logic       irq;

    int n_chk = 0;
    int n_err = 0;

    logic [7:0] miso_q[$];
    string      miso_tag[$];
    logic [7:0] rx_q[$];
    string      rx_tag[$];
    logic [7:0] got_miso;
    event       word_ev;

    always #(CLK_P/2) clk = ~clk;

    spi_slv_errdet dut_i (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
        .miso(miso), .chan_en(chan_en), .rx_only(rx_only),
        .tx_wr(tx_wr), .tx_wdata(tx_wdata), .rx_rd(rx_rd), .rx_rdata(rx_rdata),
        .clr_wr(clr_wr), .clr_mask(clr_mask), .irq_en(irq_en),
        .status(status), .irq(irq));

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // master-side driver: one word per chip-select assertion
    task automatic master_word(input logic [7:0] mo, input bit cmp, input logic [7:0] exp, input string req);
        logic [7:0] cap;
        if (cmp) begin
            miso_q.push_back(exp);
            miso_tag.push_back(req);
        end
        @(negedge clk); cs_n = 1'b0;
        wait_clk(2 * HALF);
        for (int i = 7; i >= 0; i--) begin
            mosi = mo[i];
            wait_clk(HALF);
            cap[i] = miso;
            sclk = 1'b1;
            wait_clk(HALF);
            sclk = 1'b0;
        end
        wait_clk(HALF);
        cs_n = 1'b1;
        wait_clk(3 * HALF);
        if (cmp) begin
            got_miso = cap;
            ->word_ev;
        end
        wait_clk(1);
    endtask

    task automatic host_write(input logic [7:0] d);
        @(negedge clk); tx_wr = 1'b1; tx_wdata = d;
        @(negedge clk); tx_wr = 1'b0;
    endtask

    task automatic host_read(input logic [7:0] exp, input string req);
        rx_q.push_back(exp);
        rx_tag.push_back(req);
        @(negedge clk); rx_rd = 1'b1;
        @(negedge clk); rx_rd = 1'b0;
    endtask

    task automatic clear(input logic [2:0] m);
        @(negedge clk); clr_wr = 1'b1; clr_mask = m;
        @(negedge clk); clr_wr = 1'b0; clr_mask = '0;
    endtask

    // monitors: pop expected items as results appear
    initial begin
        forever begin
            @(word_ev);
            check(miso_tag.pop_front(), {24'h0, got_miso}, {24'h0, miso_q.pop_front()});
        end
    end

    always @(posedge clk) begin
        if (rx_rd && rx_q.size() > 0)
            check(rx_tag.pop_front(), {24'h0, rx_rdata}, {24'h0, rx_q.pop_front()});
    end

    task automatic finish_run;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    endtask

    initial begin
        #(CLK_P * 150000);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual running expected done");
        finish_run();
    end

    initial begin
        wait_clk(4);
        check("R1 status", {29'h0, status}, 32'h0);
        check("R1 irq", {31'h0, irq}, 32'h0);
        check("R1 miso", {31'h0, miso}, 32'h0);
        rst_n = 1'b1;
        wait_clk(2);
        chan_en = 1'b1;
        wait_clk(4);

        // no write yet: no underflow, reset content on miso
        master_word(8'h3C, 1'b1, 8'h00, "R5 miso");
        check("R5 no underflow before write", {29'h0, status}, 32'h4);
        host_read(8'h3C, "R2 rx data");
        clear(3'b111);
        check("R8 clear all", {29'h0, status}, 32'h0);

        // normal exchange
        host_write(8'hA5);
        master_word(8'h5A, 1'b1, 8'hA5, "R2 miso");
        check("R3 filled set", {29'h0, status}, 32'h4);
        host_read(8'h5A, "R2 rx data 2");
        clear(3'b100);

        // underflow with stale retransmission
        master_word(8'h11, 1'b1, 8'hA5, "R4 stale miso");
        check("R4 underflow", {29'h0, status}, 32'h5);
        irq_en = 3'b001; wait_clk(1);
        check("R9 irq on underflow", {31'h0, irq}, 32'h1);
        clear(3'b100);
        check("R8 selective clear", {29'h0, status}, 32'h1);
        check("R9 irq held", {31'h0, irq}, 32'h1);
        host_read(8'h11, "R2 rx data 3");
        clear(3'b001);
        check("R9 irq released", {31'h0, irq}, 32'h0);

        // overflow
        host_write(8'h77);
        master_word(8'h22, 1'b1, 8'h77, "R2 miso 3");
        master_word(8'h33, 1'b1, 8'h77, "R4 stale miso 2");
        check("R6 overflow", {29'h0, status}, 32'h7);
        irq_en = 3'b000; wait_clk(1);
        check("R9 masked", {31'h0, irq}, 32'h0);
        irq_en = 3'b010; wait_clk(1);
        check("R9 overflow irq", {31'h0, irq}, 32'h1);
        irq_en = 3'b000;
        host_read(8'h33, "R6 replaced");
        clear(3'b111);

        // read empties the register
        host_write(8'h01);
        master_word(8'h44, 1'b1, 8'h01, "R2 miso 4");
        host_read(8'h44, "R3 read 1");
        clear(3'b111);
        host_write(8'h02);
        master_word(8'h55, 1'b1, 8'h02, "R2 miso 5");
        check("R3 no overflow after read", {29'h0, status}, 32'h4);
        host_read(8'h55, "R3 read 2");
        clear(3'b111);

        // receive-only
        rx_only = 1'b1;
        master_word(8'h66, 1'b0, 8'h00, "R7");
        check("R7 no underflow", {29'h0, status}, 32'h4);
        master_word(8'h67, 1'b0, 8'h00, "R7");
        check("R7 overflow", {29'h0, status}, 32'h6);
        host_read(8'h67, "R7 rx data");
        clear(3'b111);
        rx_only = 1'b0;

        // disable clears pending state
        master_word(8'h10, 1'b0, 8'h00, "R10");
        check("R4 underflow again", {29'h0, status}, 32'h5);
        clear(3'b111);
        chan_en = 1'b0; wait_clk(4);
        chan_en = 1'b1; wait_clk(4);
        master_word(8'h20, 1'b1, 8'h02, "R10 miso");
        check("R10 no error after reenable", {29'h0, status}, 32'h4);
        host_read(8'h20, "R10 rx data");
        wait_clk(4);
        finish_run();
    end
endmodule